// File: doc/BRIEF.md
# Multi-fiber instruction fetch scheduler

This block sits at the front of an instruction fetch path that keeps several lightweight hardware threads (fibers) resident at once. It holds a small pool of fiber slots, and on each cycle it either streams a fetch group from the one active fiber or spends the cycle choosing the next fiber. A group is a run of up to P instruction words. The instruction store is outside the block. It answers the presented fetch address in the same cycle with one kind code per lane. The scheduler cuts the group just after the first lane that ends a segment. The code on that lane then decides what happens next: the fiber is parked, fetch rotates to another fiber, fetch goes on along the predicted path, or the fiber retires.

Fibers are created in bulk. A single request names a start address and a count N that may be larger than the slot pool. An internal counter loads one waiting fiber per cycle into the lowest empty slot, and gives each fiber its launch index as a private identifier. It keeps refilling slots as fibers retire, until all N have been started. Mispredict reports from the back end redirect a fiber and hold it off for a fixed penalty.

Top module: `fiber_fetch_sched`

## Requirements
- R1: After reset, no slot holds a fiber, `fetch_valid` is 0 and `spawn_busy` is 0.
- R2: Lane kind codes are 0 = plain, 1 = wait branch, 2 = dismiss branch, 3 = predict branch, 4 = exit. Codes 5 to 7 count as plain. In a fetch cycle, `fetch_num` equals the index of the first lane holding code 1 to 4, plus one. If no lane holds such a code, `fetch_num` equals P. Lane i is the word at `fetch_pc`+i.
- R3: After a group that ends on a predict branch, the same fiber fetches again on the very next cycle at `fetch_pc`+`fetch_num`, unless a mispredict hits it.
- R4: After a group that ends on a wait branch, that fiber is not fetched during the next 8 cycles. With no other fiber ready, its next group comes exactly 10 cycles later: 8 stall cycles, one selection cycle, then fetch.
- R5: After a group that ends on a dismiss branch, the next cycle has `fetch_valid` low, because it is spent selecting a fiber.
- R6: On a selection cycle, the chosen fiber is the first ready slot in round-robin order, starting at the slot after the current one and wrapping back to the current one last. Empty slots and stalled slots are skipped. The chosen fiber fetches on the following cycle.
- R7: A start request is accepted only while `spawn_busy` is 0 and the count is nonzero. After acceptance, one fiber per cycle is loaded into the lowest empty slot, with `fetch_pc` set to the requested address and identifiers 0 to N-1 in launch order. `spawn_busy` stays 1 until all N have been loaded. A request made while busy is ignored.
- R8: A group that ends on an exit frees its slot. Pending fibers are then loaded into freed slots until all N have run.
- R9: A mispredict report for an occupied slot sets that fiber's address to `resolve_pc` and keeps it from fetch for 8 cycles. The report takes priority over that cycle's fetch advance.
- R10: When no fiber is ready, `fetch_valid` is 0 and `fetch_num` is 0.
- R11: A segment is never split. Two fetch cycles in a row always come from the same slot, and every change of fiber costs a cycle with `fetch_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spawn_req | input | 1 | Request to start a batch of fibers |
| spawn_pc | input | PCW | Start address of the batch |
| spawn_num | input | CNTW | Number of fibers in the batch |
| ins_kind | input | P x 3 | Kind code of each lane at the presented fetch address |
| resolve_valid | input | 1 | A branch resolution report is present |
| resolve_slot | input | SW | Slot that the report concerns |
| resolve_miss | input | 1 | The reported prediction was wrong |
| resolve_pc | input | PCW | Correct address after the mispredict |
| fetch_valid | output | 1 | A group is issued this cycle |
| fetch_slot | output | SW | Slot of the active fiber |
| fetch_pc | output | PCW | Address of lane 0 |
| fetch_num | output | CW | Number of words issued |
| fetch_fid | output | CNTW | Launch index of the active fiber |
| spawn_busy | output | 1 | Fibers of a batch are still waiting to be launched |

## Verification
The main check runs batches of fibers over a code body in which wait, dismiss, predict and exit kinds recur at fixed addresses. The batches differ in start address, in count relative to the slot pool, and in whether mispredict reports arrive. Each cycle is compared with a model kept in the bench. Batches smaller than the pool exercise plain round-robin rotation. Batches larger than the pool separate correct refill order and identifier assignment from a counter that stalls or repeats. Batches that receive redirects show whether the skipping of stalled slots and the priority of a redirect over a fetch advance are right. Directed single-fiber runs then measure exact gaps for each branch kind, and confirm that a start request made while busy leaves no trace.

// File: rtl/fsched_pkg.sv
package fsched_pkg;

   typedef enum logic [2:0] {
      K_PLAIN   = 3'd0,
      K_WAIT    = 3'd1,
      K_DISMISS = 3'd2,
      K_PREDICT = 3'd3,
      K_EXIT    = 3'd4
   } kind_e;

endpackage

// File: rtl/fsched_seg.sv
// Cuts a fetch group after the first lane that ends a segment.
module fsched_seg
   import fsched_pkg::*;
#(
   parameter int P  = 2,
   parameter int CW = 2
) (
   input  logic [P-1:0][2:0] kinds,
   output logic [CW-1:0]     num,
   output kind_e             endk
);

   logic [P-1:0] is_end;

   genvar g;
   generate
      for (g = 0; g < P; g++) begin : g_lane
         assign is_end[g] = (kinds[g] != 3'd0) && (kinds[g] <= 3'd4);
      end
   endgenerate

   always_comb begin
      num  = CW'(P);
      endk = K_PLAIN;
      for (int i = P - 1; i >= 0; i--) begin
         if (is_end[i]) begin
            num  = CW'(i + 1);
            endk = kind_e'(kinds[i]);
         end
      end
   end

endmodule

// File: rtl/fsched_pick.sv
// Selects the next ready slot; RR=1 rotates after base, RR=0 takes the lowest index.
module fsched_pick #(
   parameter int N  = 4,
   parameter int SW = 2,
   parameter bit RR = 1'b1
) (
   input  logic [N-1:0]  req,
   input  logic [SW-1:0] base,
   output logic [SW-1:0] pick,
   output logic          found
);

   generate
      if (RR) begin : g_rr
         always_comb begin
            pick  = '0;
            found = 1'b0;
            for (int k = N; k >= 1; k--) begin
               int idx;
               idx = (int'(base) + k) % N;
               if (req[idx]) begin
                  pick  = SW'(idx);
                  found = 1'b1;
               end
            end
         end
      end else begin : g_fixed
         logic unused_base;
         assign unused_base = ^base;
         always_comb begin
            pick  = '0;
            found = 1'b0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) begin
                  pick  = SW'(i);
                  found = 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/fsched_spawn.sv
// Bulk launch counter: loads one pending fiber per cycle into the lowest free slot.
module fsched_spawn #(
   parameter int N    = 4,
   parameter int SW   = 2,
   parameter int PCW  = 16,
   parameter int CNTW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic [CNTW-1:0] req_num,
   input  logic [PCW-1:0]  req_pc,
   input  logic [N-1:0]    slot_vld,
   output logic            load_en,
   output logic [SW-1:0]   load_slot,
   output logic [CNTW-1:0] load_fid,
   output logic [PCW-1:0]  load_pc,
   output logic            busy
);

   logic [CNTW-1:0] rem_q;
   logic [CNTW-1:0] nfid_q;
   logic [PCW-1:0]  bpc_q;
   logic            free_any;

   always_comb begin
      load_slot = '0;
      free_any  = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!slot_vld[i]) begin
            load_slot = SW'(i);
            free_any  = 1'b1;
         end
      end
   end

   assign busy     = (rem_q != '0);
   assign load_en  = busy && free_any;
   assign load_fid = nfid_q;
   assign load_pc  = bpc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         nfid_q <= '0;
         bpc_q  <= '0;
      end else if (!busy) begin
         if (req && req_num != '0) begin
            rem_q  <= req_num;
            nfid_q <= '0;
            bpc_q  <= req_pc;
         end
      end else if (load_en) begin
         rem_q  <= rem_q - 1'b1;
         nfid_q <= nfid_q + 1'b1;
      end
   end

   // R7: a batch can only finish right after a launch
   a_r7_busy_ends_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(load_en));

   // R7: the launch address stays fixed while a batch is pending
   a_r7_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(bpc_q));

endmodule

// File: rtl/fiber_fetch_sched.sv
module fiber_fetch_sched
   import fsched_pkg::*;
#(
   parameter int NSLOT     = 4,
   parameter int P         = 2,
   parameter int PCW       = 16,
   parameter int CNTW      = 8,
   parameter int STALL_CYC = 8,
   parameter bit RR_PICK   = 1'b1,
   localparam int SW       = (NSLOT > 1) ? $clog2(NSLOT) : 1,
   localparam int CW       = $clog2(P + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                spawn_req,
   input  logic [PCW-1:0]      spawn_pc,
   input  logic [CNTW-1:0]     spawn_num,
   input  logic [P-1:0][2:0]   ins_kind,
   input  logic                resolve_valid,
   input  logic [SW-1:0]       resolve_slot,
   input  logic                resolve_miss,
   input  logic [PCW-1:0]      resolve_pc,
   output logic                fetch_valid,
   output logic [SW-1:0]       fetch_slot,
   output logic [PCW-1:0]      fetch_pc,
   output logic [CW-1:0]       fetch_num,
   output logic [CNTW-1:0]     fetch_fid,
   output logic                spawn_busy
);

   localparam logic [3:0] STL = 4'(STALL_CYC);

   initial begin
      assert (NSLOT >= 2) else $error("NSLOT must be at least 2");
      assert (P >= 1) else $error("P must be at least 1");
      assert (STALL_CYC >= 1 && STALL_CYC <= 15) else $error("STALL_CYC must fit the 4-bit countdown");
      assert (CNTW >= SW) else $error("CNTW too narrow");
   end

   logic [PCW-1:0]  pc_q  [NSLOT];
   logic [3:0]      stl_q [NSLOT];
   logic [CNTW-1:0] fid_q [NSLOT];
   logic [NSLOT-1:0] vld_q;
   logic [NSLOT-1:0] rdy;
   logic [SW-1:0]   cur_q;
   logic            act_q;

   logic            go;
   logic            rel;
   logic [CW-1:0]   seg_num;
   kind_e           seg_end;
   logic [SW-1:0]   nxt_pick;
   logic            nxt_found;
   logic            load_en;
   logic [SW-1:0]   load_slot;
   logic [CNTW-1:0] load_fid;
   logic [PCW-1:0]  load_pc;

   fsched_seg #(.P(P), .CW(CW)) u_seg (
      .kinds (ins_kind),
      .num   (seg_num),
      .endk  (seg_end)
   );

   fsched_pick #(.N(NSLOT), .SW(SW), .RR(RR_PICK)) u_pick (
      .req   (rdy),
      .base  (cur_q),
      .pick  (nxt_pick),
      .found (nxt_found)
   );

   fsched_spawn #(.N(NSLOT), .SW(SW), .PCW(PCW), .CNTW(CNTW)) u_spawn (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (spawn_req),
      .req_num   (spawn_num),
      .req_pc    (spawn_pc),
      .slot_vld  (vld_q),
      .load_en   (load_en),
      .load_slot (load_slot),
      .load_fid  (load_fid),
      .load_pc   (load_pc),
      .busy      (spawn_busy)
   );

   assign go  = act_q && rdy[cur_q];
   assign rel = go && (seg_end == K_WAIT || seg_end == K_DISMISS || seg_end == K_EXIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q <= '0;
         act_q <= 1'b0;
      end else if (go) begin
         if (rel) act_q <= 1'b0;
      end else begin
         act_q <= nxt_found;
         if (nxt_found) cur_q <= nxt_pick;
      end
   end

   genvar g;
   generate
      for (g = 0; g < NSLOT; g++) begin : g_slot
         logic sel, hit, ld;
         assign rdy[g] = vld_q[g] && (stl_q[g] == 4'd0);
         assign sel    = go && (cur_q == SW'(g));
         assign hit    = resolve_valid && resolve_miss && (resolve_slot == SW'(g)) && vld_q[g];
         assign ld     = load_en && (load_slot == SW'(g));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q[g] <= 1'b0;
               pc_q[g]  <= '0;
               stl_q[g] <= 4'd0;
               fid_q[g] <= '0;
            end else if (ld) begin
               vld_q[g] <= 1'b1;
               pc_q[g]  <= load_pc;
               stl_q[g] <= 4'd0;
               fid_q[g] <= load_fid;
            end else begin
               if (sel && seg_end == K_EXIT) vld_q[g] <= 1'b0;
               if (hit) pc_q[g] <= resolve_pc;
               else if (sel) pc_q[g] <= pc_q[g] + PCW'(seg_num);
               if (hit || (sel && seg_end == K_WAIT)) stl_q[g] <= STL;
               else if (stl_q[g] != 4'd0) stl_q[g] <= stl_q[g] - 4'd1;
            end
         end

         // R9: the countdown never exceeds the penalty length
         a_r9_stall_max: assert property (@(posedge clk) disable iff (!rst_n)
            stl_q[g] <= STL);
      end
   endgenerate

   assign fetch_valid = go;
   assign fetch_slot  = cur_q;
   assign fetch_pc    = pc_q[cur_q];
   assign fetch_fid   = fid_q[cur_q];
   assign fetch_num   = go ? seg_num : '0;

   // R2: an issued group holds between one and P words
   a_r2_num_range: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |-> (fetch_num != '0) && (fetch_num <= CW'(P)));

   // R11: back-to-back fetch cycles come from one slot
   a_r11_seg_atomic: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid && $past(fetch_valid) |-> fetch_slot == $past(fetch_slot));

   // R5: a dismiss is followed by a selection bubble
   a_r5_dismiss_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fetch_valid && seg_end == K_DISMISS) |-> !fetch_valid);

   // R4: a waiting fiber is not fetched on the next cycle
   a_r4_wait_park: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fetch_valid && seg_end == K_WAIT) |-> !fetch_valid);

   // R3: a predicted branch continues the same fiber without a bubble
   a_r3_predict_flow: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fetch_valid && seg_end == K_PREDICT &&
            !(resolve_valid && resolve_miss && resolve_slot == fetch_slot))
      |-> fetch_valid && fetch_pc == $past(fetch_pc + PCW'(fetch_num)));

   // R10: nothing is issued while idle
   a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_valid |-> fetch_num == '0);

endmodule

// File: tb/fiber_fetch_sched_tb_top.sv
`timescale 1ns/1ps
module fiber_fetch_sched_tb_top;

   localparam int NS   = 4;
   localparam int P    = 2;
   localparam int PCW  = 16;
   localparam int CNTW = 8;
   localparam int SW   = 2;
   localparam int CW   = 2;
   localparam int PEN  = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic                rst_n;
   logic                spawn_req;
   logic [PCW-1:0]      spawn_pc;
   logic [CNTW-1:0]     spawn_num;
   logic [P-1:0][2:0]   ins_kind;
   logic                resolve_valid;
   logic [SW-1:0]       resolve_slot;
   logic                resolve_miss;
   logic [PCW-1:0]      resolve_pc;
   logic                fetch_valid;
   logic [SW-1:0]       fetch_slot;
   logic [PCW-1:0]      fetch_pc;
   logic [CW-1:0]       fetch_num;
   logic [CNTW-1:0]     fetch_fid;
   logic                spawn_busy;

   fiber_fetch_sched #(.NSLOT(NS), .P(P), .PCW(PCW), .CNTW(CNTW), .STALL_CYC(PEN)) dut_i (
      .clk(clk), .rst_n(rst_n), .spawn_req(spawn_req), .spawn_pc(spawn_pc),
      .spawn_num(spawn_num), .ins_kind(ins_kind), .resolve_valid(resolve_valid),
      .resolve_slot(resolve_slot), .resolve_miss(resolve_miss), .resolve_pc(resolve_pc),
      .fetch_valid(fetch_valid), .fetch_slot(fetch_slot), .fetch_pc(fetch_pc),
      .fetch_num(fetch_num), .fetch_fid(fetch_fid), .spawn_busy(spawn_busy)
   );

   // code body: branch at offset 5 of every 8 words, kind from bits 4:3; exit at 63
   function automatic logic [2:0] k_of(input logic [PCW-1:0] pc);
      if (pc[5:0] == 6'd63) return 3'd4;
      if (pc[2:0] == 3'd5) begin
         case (pc[4:3])
            2'd0:    return 3'd1;
            2'd2:    return 3'd3;
            default: return 3'd2;
         endcase
      end
      return 3'd0;
   endfunction

   always_comb begin
      for (int i = 0; i < P; i++) ins_kind[i] = k_of(fetch_pc + PCW'(i));
   end

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   // reference model state
   bit            m_vld [NS];
   logic [PCW-1:0] m_pc [NS];
   int            m_stl [NS];
   int            m_fid [NS];
   int            m_cur;
   bit            m_act;
   int            m_rem;
   int            m_nfid;
   logic [PCW-1:0] m_bpc;

   // observation helpers
   int  last_fcyc, last_gap;
   logic [PCW-1:0] last_fpc;
   bit  got_fetch;
   int  fid_mask;
   int  min_pc;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s cycle=%0d act=%0d exp=%0d", tag, cyc, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < NS; i++) begin
         m_vld[i] = 0; m_pc[i] = '0; m_stl[i] = 0; m_fid[i] = 0;
      end
      m_cur = 0; m_act = 0; m_rem = 0; m_nfid = 0; m_bpc = '0;
      last_fcyc = 0; last_gap = 0; last_fpc = '0; got_fetch = 0;
      fid_mask = 0; min_pc = 1 << 20;
   endtask

   // one cycle: called just after a falling edge with inputs already driven
   task automatic step();
      bit e_go, found, res_hit;
      int e_num, e_end, pick, ld, old_rem;
      #1;
      e_go  = m_act && m_vld[m_cur] && (m_stl[m_cur] == 0);
      e_num = P; e_end = 0;
      for (int i = P - 1; i >= 0; i--) begin
         int k;
         k = int'(k_of(m_pc[m_cur] + PCW'(i)));
         if (k >= 1 && k <= 4) begin e_num = i + 1; e_end = k; end
      end
      chk(fetch_valid === e_go, "R6 fetch_valid", int'(fetch_valid), int'(e_go));
      if (e_go && fetch_valid) begin
         chk(int'(fetch_slot) == m_cur, "R6 fetch_slot", int'(fetch_slot), m_cur);
         chk(fetch_pc == m_pc[m_cur], "R3 fetch_pc", int'(fetch_pc), int'(m_pc[m_cur]));
         chk(int'(fetch_num) == e_num, "R2 fetch_num", int'(fetch_num), e_num);
         chk(int'(fetch_fid) == m_fid[m_cur], "R7 fetch_fid", int'(fetch_fid), m_fid[m_cur]);
      end
      if (!e_go) chk(fetch_num == '0, "R10 fetch_num idle", int'(fetch_num), 0);
      chk(spawn_busy === (m_rem != 0), "R7 spawn_busy", int'(spawn_busy), int'(m_rem != 0));

      got_fetch = fetch_valid;
      if (fetch_valid) begin
         last_gap  = cyc - last_fcyc;
         last_fcyc = cyc;
         last_fpc  = fetch_pc;
         fid_mask  = fid_mask | (1 << int'(fetch_fid));
         if (int'(fetch_pc) < min_pc) min_pc = int'(fetch_pc);
      end

      // model next state
      found = 0; pick = 0;
      for (int k = NS; k >= 1; k--) begin
         int idx;
         idx = (m_cur + k) % NS;
         if (m_vld[idx] && m_stl[idx] == 0) begin found = 1; pick = idx; end
      end
      ld = -1;
      if (m_rem != 0)
         for (int i = NS - 1; i >= 0; i--) if (!m_vld[i]) ld = i;
      res_hit = resolve_valid && resolve_miss && m_vld[int'(resolve_slot)];
      old_rem = m_rem;
      for (int i = 0; i < NS; i++) if (m_stl[i] != 0) m_stl[i]--;
      if (e_go) begin
         if (e_end == 1) m_stl[m_cur] = PEN;
         if (e_end == 4) m_vld[m_cur] = 0;
         m_pc[m_cur] = m_pc[m_cur] + PCW'(e_num);
         if (e_end == 1 || e_end == 2 || e_end == 4) m_act = 0;
      end else begin
         m_act = found;
         if (found) m_cur = pick;
      end
      if (res_hit) begin
         m_pc[int'(resolve_slot)]  = resolve_pc;
         m_stl[int'(resolve_slot)] = PEN;
      end
      if (ld >= 0) begin
         m_vld[ld] = 1; m_pc[ld] = m_bpc; m_stl[ld] = 0; m_fid[ld] = m_nfid;
         m_nfid++; m_rem--;
      end
      if (old_rem == 0 && spawn_req && spawn_num != '0) begin
         m_rem = int'(spawn_num); m_nfid = 0; m_bpc = spawn_pc;
      end
      cyc++;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      spawn_req = 0; spawn_pc = '0; spawn_num = '0;
      resolve_valid = 0; resolve_slot = '0; resolve_miss = 0; resolve_pc = '0;
      model_clear();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic spawn(input int base, input int n);
      spawn_req = 1; spawn_pc = PCW'(base); spawn_num = CNTW'(n);
      step();
      spawn_req = 0;
   endtask

   function automatic bit model_empty();
      bit any;
      any = (m_rem != 0);
      for (int i = 0; i < NS; i++) any = any | m_vld[i];
      return !any;
   endfunction

   task automatic run_idle(input int cap);
      for (int c = 0; c < cap; c++) begin
         if (model_empty()) break;
         step();
      end
   endtask

   task automatic run_to_pc(input int pc, input int cap);
      for (int c = 0; c < cap; c++) begin
         step();
         if (got_fetch && int'(last_fpc) == pc) break;
      end
   endtask

   // scenario table: {base[7:0], count[7:0], mispredict_enable}
   localparam int NSCN = 6;
   localparam logic [16:0] SCN [NSCN] = '{
      {8'd0,  8'd3, 1'b0},
      {8'd8,  8'd6, 1'b0},
      {8'd36, 8'd5, 1'b1},
      {8'd20, 8'd9, 1'b1},
      {8'd44, 8'd2, 1'b0},
      {8'd56, 8'd8, 1'b1}
   };

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      do_reset();
      // R1: reset state
      #1;
      chk(fetch_valid === 1'b0, "R1 fetch_valid after reset", int'(fetch_valid), 0);
      chk(spawn_busy === 1'b0, "R1 spawn_busy after reset", int'(spawn_busy), 0);
      @(negedge clk);

      // table-driven batches compared cycle by cycle with the model
      for (int s = 0; s < NSCN; s++) begin
         int lc;
         do_reset();
         spawn(int'(SCN[s][16:9]), int'(SCN[s][8:1]));
         lc = 0;
         while (!model_empty() && lc < 3000) begin
            if (SCN[s][0] && (lc % 17) == 9) begin
               resolve_valid = 1; resolve_miss = 1;
               resolve_slot = SW'((lc / 17) % NS); resolve_pc = PCW'(40);
            end
            step();
            resolve_valid = 0; resolve_miss = 0;
            lc++;
         end
         chk(model_empty(), "R8 batch drains", lc, 0);
         step();
         chk(fetch_valid === 1'b0, "R10 idle after batch", int'(fetch_valid), 0);
      end

      // directed: single fiber gaps for each branch kind
      do_reset();
      spawn(4, 1);
      run_to_pc(6, 100);
      chk(last_gap == 10, "R4 wait gap", last_gap, 10);
      run_to_pc(14, 100);
      chk(last_gap == 2, "R5 dismiss gap", last_gap, 2);
      run_to_pc(22, 100);
      chk(last_gap == 1, "R3 predict gap", last_gap, 1);
      run_idle(500);
      step(); step();
      chk(fetch_valid === 1'b0, "R10 no ready fiber", int'(fetch_valid), 0);
      chk(spawn_busy === 1'b0, "R8 single fiber retired", int'(spawn_busy), 0);

      // directed: refill beyond pool size, and a request while busy is ignored
      do_reset();
      spawn(60, 6);
      step();
      spawn(0, 3);
      run_idle(800);
      chk(fid_mask == 32'h3f, "R8 all six fibers ran", fid_mask, 32'h3f);
      chk(min_pc >= 60, "R7 busy request ignored", min_pc, 60);

      // directed: mispredict redirect and penalty
      do_reset();
      spawn(20, 1);
      run_to_pc(22, 100);
      begin
         int rcyc;
         rcyc = cyc;
         resolve_valid = 1; resolve_miss = 1; resolve_slot = '0; resolve_pc = PCW'(40);
         step();
         resolve_valid = 0; resolve_miss = 0;
         run_to_pc(40, 100);
         chk(int'(last_fpc) == 40, "R9 redirect address", int'(last_fpc), 40);
         chk(last_fcyc - rcyc == 10, "R9 redirect penalty", last_fcyc - rcyc, 10);
      end
      run_idle(500);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule